// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the processor's current status word and the five saved status words that belong to the exception modes. Each cycle it looks at the pending exception requests, drops any interrupt that the current status masks, and picks one winner by fixed priority. In a single clock edge it then preserves the current status in the winner's saved register, switches to the winner's mode in the 32-bit instruction state with the normal interrupt masked (and, for reset and the fast interrupt, the fast interrupt masked too), and presents a vector address plus the link value the register file must write into that mode's r14.

A return request copies the active mode's saved status back into the current status and loads the program counter from the link register value the register file supplies. A direct write port lets privileged code replace the current or the saved status word; from user mode it may change only the condition and saturation flags. The outputs drive the fetch unit (new program counter with a load strobe) and the banked register file (mode field and link write).

Top module: `trap_seq`

## Requirements
- R1: After `rst_n` is released the status word reads 0x000000D3: supervisor mode (mode field bits 4..0 = 10011), I (bit 7) = 1, F (bit 6) = 1, T (bit 5) = 0, flags zero; `pc_load`, `lr_we` are 0 and `spsr_out` is 0.
- R2: An accepted exception takes effect at the next clock edge: for one cycle `pc_load` and `lr_we` are 1, `pc_out` holds the vector and `lr_out` holds the `cur_pc` sampled at that edge.
- R3: The vector is base + offset with offsets reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C; base is 0 when `hivec` = 0 and 0xFFFF0000 when `hivec` = 1.
- R4: Target modes: reset and software interrupt to supervisor (10011), both aborts to abort (10111), undefined to undefined (11011), interrupt to 10010, fast interrupt to 10001; user is 10000 and system 11111.
- R5: On entry the previous status word is stored in the target mode's saved register (seen on `spsr_out`), T is cleared, I is set, flags are kept; F is set only for reset and fast interrupt and otherwise kept.
- R6: Simultaneous requests are served in the order reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R7: An interrupt request while I = 1, or a fast interrupt request while F = 1, is ignored: no load strobe and no state change result from it.
- R8: A return in a mode that has a saved register restores the status from it and loads `pc_out` from `lr_in` with `pc_load` = 1 and `lr_we` = 0; a return in user or system mode has no effect.
- R9: A direct status write (`sr_wr_en`, `sr_wr_spsr` = 0) in user mode changes only bits 31..27; in any other mode it replaces the whole word.
- R10: A saved-register write (`sr_wr_spsr` = 1) in user or system mode is ignored and `spsr_out` reads 0 there; in an exception mode it replaces that mode's saved word.
- R11: An exception request takes precedence over a return or a status write in the same cycle; a return takes precedence over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| hivec | input | 1 | Select high vector base |
| cur_pc | input | 32 | Return address to save on entry |
| ret_req | input | 1 | Exception return request |
| lr_in | input | 32 | Link register value for return |
| sr_wr_en | input | 1 | Status write enable |
| sr_wr_spsr | input | 1 | 1 selects saved register, 0 current |
| sr_wr_data | input | 32 | Status write data |
| pc_out | output | 32 | New program counter |
| pc_load | output | 1 | Program counter load strobe |
| lr_out | output | 32 | Link value for the banked r14 |
| lr_we | output | 1 | Link register write strobe |
| mode_out | output | 5 | Current mode field |
| irq_mask | output | 1 | I bit |
| fiq_mask | output | 1 | F bit |
| thumb | output | 1 | T bit |
| cpsr_out | output | 32 | Current status word |
| spsr_out | output | 32 | Saved status word of the current mode |

## Verification
On every cycle the assertions check that a link write always comes with a program counter load, that each entry lands in an exception mode in the 32-bit state with I set and the prior status captured in the new mode's saved register, that vectors are word aligned at one of the two bases, that user mode keeps its non-flag bits, and that fully masked interrupts raise nothing. The exact vector per exception, the priority order among many simultaneous requests, the return path and the ignored saved-register writes in user mode are shown only by the bench's scenarios, which compare every strobe and status word against a model built from the requirements.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_SAVED = 5;
    localparam int NUM_KIND  = 8;
    localparam int SLOT_W    = $clog2(NUM_SAVED);
    localparam int MODE_W    = 5;

    // status word bit positions
    localparam int BIT_I   = 7;
    localparam int BIT_F   = 6;
    localparam int BIT_T   = 5;
    localparam int FLAG_LO = 27;

    // the value is the vector slot number (offset = value * 4)
    typedef enum logic [2:0] {
        EX_RST  = 3'd0,
        EX_UND  = 3'd1,
        EX_SWI  = 3'd2,
        EX_PABT = 3'd3,
        EX_DABT = 3'd4,
        EX_RSVD = 3'd5,
        EX_IRQ  = 3'd6,
        EX_FIQ  = 3'd7
    } exc_kind_e;

    localparam logic [MODE_W-1:0] M_USR = 5'b10000;
    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;
    localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_t;

    function automatic slot_t saved_slot(input logic [MODE_W-1:0] m);
        slot_t s;
        s.hit = 1'b1;
        unique case (m)
            M_FIQ:   s.idx = SLOT_W'(0);
            M_IRQ:   s.idx = SLOT_W'(1);
            M_SVC:   s.idx = SLOT_W'(2);
            M_ABT:   s.idx = SLOT_W'(3);
            M_UND:   s.idx = SLOT_W'(4);
            default: begin s.hit = 1'b0; s.idx = '0; end
        endcase
        return s;
    endfunction

    typedef struct packed {
        logic [NUM_SAVED-1:0][WORD_W-1:0] spsr;
        logic [WORD_W-1:0]                cpsr;
        logic [WORD_W-1:0]                pc;
        logic [WORD_W-1:0]                lr;
        logic                             pc_load;
        logic                             lr_we;
    } seq_state_t;

endpackage

// File: rtl/trap_arb.sv
module trap_arb
    import trap_pkg::*;
#(
    parameter int PRIO_N = 7
) (
    input  logic [NUM_KIND-1:0] req,
    output logic                valid,
    output exc_kind_e           kind
);

    // rank 0 is the most urgent
    function automatic exc_kind_e rank_kind(input int r);
        case (r)
            0:       return EX_RST;
            1:       return EX_DABT;
            2:       return EX_FIQ;
            3:       return EX_IRQ;
            4:       return EX_PABT;
            5:       return EX_UND;
            default: return EX_SWI;
        endcase
    endfunction

    always_comb begin
        valid = 1'b0;
        kind  = EX_RST;
        for (int r = PRIO_N - 1; r >= 0; r--) begin
            if (req[int'(rank_kind(r))]) begin
                valid = 1'b1;
                kind  = rank_kind(r);
            end
        end
    end

endmodule

// File: rtl/trap_vec.sv
module trap_vec
    import trap_pkg::*;
#(
    parameter logic [WORD_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  exc_kind_e          kind,
    input  logic               hivec,
    output logic [WORD_W-1:0]  vec_addr,
    output logic [MODE_W-1:0]  tgt_mode,
    output logic               set_f
);

    localparam int OFS_W = $bits(exc_kind_e) + 2;

    always_comb begin
        vec_addr = (hivec ? HI_BASE : '0) | WORD_W'({kind, 2'b00});
        set_f    = (kind == EX_RST) || (kind == EX_FIQ);
        unique case (kind)
            EX_RST, EX_SWI:   tgt_mode = M_SVC;
            EX_PABT, EX_DABT: tgt_mode = M_ABT;
            EX_UND:           tgt_mode = M_UND;
            EX_IRQ:           tgt_mode = M_IRQ;
            EX_FIQ:           tgt_mode = M_FIQ;
            default:          tgt_mode = M_SVC;
        endcase
    end

    initial assert (OFS_W < WORD_W);

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter logic [WORD_W-1:0] HI_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rst,
    input  logic              req_und,
    input  logic              req_swi,
    input  logic              req_pabt,
    input  logic              req_dabt,
    input  logic              req_irq,
    input  logic              req_fiq,
    input  logic              hivec,
    input  logic [31:0]       cur_pc,
    input  logic              ret_req,
    input  logic [31:0]       lr_in,
    input  logic              sr_wr_en,
    input  logic              sr_wr_spsr,
    input  logic [31:0]       sr_wr_data,
    output logic [31:0]       pc_out,
    output logic              pc_load,
    output logic [31:0]       lr_out,
    output logic              lr_we,
    output logic [4:0]        mode_out,
    output logic              irq_mask,
    output logic              fiq_mask,
    output logic              thumb,
    output logic [31:0]       cpsr_out,
    output logic [31:0]       spsr_out
);

    localparam logic [WORD_W-1:0] RESET_CPSR =
        WORD_W'((1 << BIT_I) | (1 << BIT_F)) | WORD_W'(M_SVC);

    seq_state_t st_d, st_q;

    logic [NUM_KIND-1:0] eff_req;
    logic                grant_vld;
    exc_kind_e           grant_kind;
    logic [WORD_W-1:0]   vec_addr;
    logic [MODE_W-1:0]   tgt_mode;
    logic                tgt_set_f;
    slot_t               cur_slot;
    slot_t               tgt_slot;

    // masked interrupts never reach the arbiter
    always_comb begin
        eff_req                = '0;
        eff_req[int'(EX_RST)]  = req_rst;
        eff_req[int'(EX_UND)]  = req_und;
        eff_req[int'(EX_SWI)]  = req_swi;
        eff_req[int'(EX_PABT)] = req_pabt;
        eff_req[int'(EX_DABT)] = req_dabt;
        eff_req[int'(EX_IRQ)]  = req_irq & ~st_q.cpsr[BIT_I];
        eff_req[int'(EX_FIQ)]  = req_fiq & ~st_q.cpsr[BIT_F];
    end

    trap_arb u_arb (
        .req   (eff_req),
        .valid (grant_vld),
        .kind  (grant_kind)
    );

    trap_vec #(.HI_BASE(HI_BASE)) u_vec (
        .kind     (grant_kind),
        .hivec    (hivec),
        .vec_addr (vec_addr),
        .tgt_mode (tgt_mode),
        .set_f    (tgt_set_f)
    );

    assign cur_slot = saved_slot(st_q.cpsr[MODE_W-1:0]);
    assign tgt_slot = saved_slot(tgt_mode);

    always_comb begin
        st_d         = st_q;
        st_d.pc_load = 1'b0;
        st_d.lr_we   = 1'b0;
        if (grant_vld) begin
            st_d.spsr[tgt_slot.idx]      = st_q.cpsr;
            st_d.cpsr[MODE_W-1:0]        = tgt_mode;
            st_d.cpsr[BIT_T]             = 1'b0;
            st_d.cpsr[BIT_I]             = 1'b1;
            if (tgt_set_f) st_d.cpsr[BIT_F] = 1'b1;
            st_d.pc                      = vec_addr;
            st_d.lr                      = cur_pc;
            st_d.pc_load                 = 1'b1;
            st_d.lr_we                   = 1'b1;
        end else if (ret_req && cur_slot.hit) begin
            st_d.cpsr    = st_q.spsr[cur_slot.idx];
            st_d.pc      = lr_in;
            st_d.pc_load = 1'b1;
        end else if (sr_wr_en) begin
            if (!sr_wr_spsr) begin
                if (st_q.cpsr[MODE_W-1:0] == M_USR)
                    st_d.cpsr[WORD_W-1:FLAG_LO] = sr_wr_data[WORD_W-1:FLAG_LO];
                else
                    st_d.cpsr = sr_wr_data;
            end else if (cur_slot.hit) begin
                st_d.spsr[cur_slot.idx] = sr_wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cpsr    <= RESET_CPSR;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_out   = st_q.pc;
    assign pc_load  = st_q.pc_load;
    assign lr_out   = st_q.lr;
    assign lr_we    = st_q.lr_we;
    assign mode_out = st_q.cpsr[MODE_W-1:0];
    assign irq_mask = st_q.cpsr[BIT_I];
    assign fiq_mask = st_q.cpsr[BIT_F];
    assign thumb    = st_q.cpsr[BIT_T];
    assign cpsr_out = st_q.cpsr;
    assign spsr_out = cur_slot.hit ? st_q.spsr[cur_slot.idx] : '0;

    AST_LINK_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> pc_load); // R2

    AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (!thumb && irq_mask &&
                   (mode_out == M_FIQ || mode_out == M_IRQ || mode_out == M_SVC ||
                    mode_out == M_ABT || mode_out == M_UND))); // R4

    AST_SAVED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lr_we) |-> spsr_out == $past(cpsr_out)); // R5

    AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (pc_out[1:0] == 2'b00 &&
                   (pc_out[31:5] == '0 || pc_out[31:5] == HI_BASE[31:5]))); // R3

    AST_USER_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == M_USR) |=> (lr_we || cpsr_out[26:0] == $past(cpsr_out[26:0]))); // R9

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask && fiq_mask && !req_rst && !req_und && !req_swi &&
         !req_pabt && !req_dabt) |=> !lr_we); // R7

endmodule

// File: tb/trap_seq_bench.sv
module trap_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rst = 0, req_und = 0, req_swi = 0, req_pabt = 0;
    logic        req_dabt = 0, req_irq = 0, req_fiq = 0, hivec = 0;
    logic [31:0] cur_pc = '0, lr_in = '0, sr_wr_data = '0;
    logic        ret_req = 0, sr_wr_en = 0, sr_wr_spsr = 0;
    logic [31:0] pc_out, lr_out, cpsr_out, spsr_out;
    logic        pc_load, lr_we, irq_mask, fiq_mask, thumb;
    logic [4:0]  mode_out;

    always #5 clk = ~clk;

    trap_seq u_trap_seq (
        .clk(clk), .rst_n(rst_n),
        .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq),
        .req_fiq(req_fiq), .hivec(hivec), .cur_pc(cur_pc),
        .ret_req(ret_req), .lr_in(lr_in), .sr_wr_en(sr_wr_en),
        .sr_wr_spsr(sr_wr_spsr), .sr_wr_data(sr_wr_data),
        .pc_out(pc_out), .pc_load(pc_load), .lr_out(lr_out), .lr_we(lr_we),
        .mode_out(mode_out), .irq_mask(irq_mask), .fiq_mask(fiq_mask),
        .thumb(thumb), .cpsr_out(cpsr_out), .spsr_out(spsr_out)
    );

    typedef struct {
        logic        load;
        logic [31:0] pc;
        logic        we;
        logic [31:0] lr;
        logic [31:0] cpsr;
        logic [31:0] spsr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // bench model of the architectural state
    logic [31:0] m_cpsr;
    logic [31:0] m_spsr [5];

    function automatic int slot_of(logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    task automatic model_reset();
        m_cpsr = 32'h0000_00D3;
        for (int i = 0; i < 5; i++) m_spsr[i] = '0;
    endtask

    // rq bits: 0 reset, 1 undefined, 2 swi, 3 prefetch abort, 4 data abort, 6 irq, 7 fiq
    task automatic op(logic [7:0] rq, bit ret, bit wr, bit wsp, logic [31:0] wd,
                      logic [31:0] pc, logic [31:0] lr, bit hv, string tag);
        exp_t e;
        int   win;
        int   ord [7] = '{0, 4, 7, 6, 3, 1, 2};
        logic [7:0] eff;
        @(negedge clk);
        {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_und, req_rst} =
            {rq[7], rq[6], rq[4], rq[3], rq[2], rq[1], rq[0]};
        ret_req = ret; sr_wr_en = wr; sr_wr_spsr = wsp; sr_wr_data = wd;
        cur_pc = pc; lr_in = lr; hivec = hv;
        eff = rq;
        eff[5] = 1'b0;
        if (m_cpsr[7]) eff[6] = 1'b0;
        if (m_cpsr[6]) eff[7] = 1'b0;
        win = -1;
        for (int i = 6; i >= 0; i--) if (eff[ord[i]]) win = ord[i];
        e.load = 0; e.we = 0; e.pc = '0; e.lr = '0; e.tag = tag;
        if (win >= 0) begin
            logic [4:0] tm;
            case (win)
                0, 2:    tm = 5'b10011;
                3, 4:    tm = 5'b10111;
                1:       tm = 5'b11011;
                6:       tm = 5'b10010;
                default: tm = 5'b10001;
            endcase
            m_spsr[slot_of(tm)] = m_cpsr;
            m_cpsr[4:0] = tm;
            m_cpsr[5] = 1'b0;
            m_cpsr[7] = 1'b1;
            if (win == 0 || win == 7) m_cpsr[6] = 1'b1;
            e.load = 1; e.we = 1; e.lr = pc;
            e.pc = (hv ? 32'hFFFF_0000 : 32'h0) + 32'(win * 4);
        end else if (ret && slot_of(m_cpsr[4:0]) >= 0) begin
            m_cpsr = m_spsr[slot_of(m_cpsr[4:0])];
            e.load = 1; e.pc = lr;
        end else if (wr) begin
            if (!wsp) begin
                if (m_cpsr[4:0] == 5'b10000) m_cpsr[31:27] = wd[31:27];
                else m_cpsr = wd;
            end else if (slot_of(m_cpsr[4:0]) >= 0) begin
                m_spsr[slot_of(m_cpsr[4:0])] = wd;
            end
        end
        e.cpsr = m_cpsr;
        e.spsr = (slot_of(m_cpsr[4:0]) >= 0) ? m_spsr[slot_of(m_cpsr[4:0])] : 32'h0;
        q.push_back(e);
    endtask

    task automatic idle(string tag);
        op(8'h00, 0, 0, 0, 32'h0, 32'h0, 32'h0, 0, tag);
    endtask

    // monitor: compares the result of each edge shortly after it
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (pc_load !== e.load || lr_we !== e.we ||
                (e.load && pc_out !== e.pc) || (e.we && lr_out !== e.lr) ||
                cpsr_out !== e.cpsr || spsr_out !== e.spsr ||
                mode_out !== e.cpsr[4:0] || irq_mask !== e.cpsr[7] ||
                fiq_mask !== e.cpsr[6] || thumb !== e.cpsr[5]) begin
                n_bad++;
                $display("FAIL %s: got load=%0b pc=%h we=%0b lr=%h cpsr=%h spsr=%h exp load=%0b pc=%h we=%0b lr=%h cpsr=%h spsr=%h",
                         e.tag, pc_load, pc_out, lr_we, lr_out, cpsr_out, spsr_out,
                         e.load, e.pc, e.we, e.lr, e.cpsr, e.spsr);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        op(8'h00, 0, 1, 0, 32'hA000_0030, 0, 0, 0, "R9 privileged write to user");
        op(8'h00, 0, 1, 0, 32'h5000_00D3, 0, 0, 0, "R9 user write keeps control");
        op(8'h00, 0, 1, 1, 32'h1234_5678, 0, 0, 0, "R10 saved write in user ignored");
        op(8'h00, 1, 0, 0, 32'h0, 0, 32'h0000_2000, 0, "R8 return in user ignored");
        op(8'h40, 0, 0, 0, 32'h0, 32'h0000_1000, 0, 0, "R2 R3 R4 R5 irq entry");
        op(8'h40, 0, 0, 0, 32'h0, 32'h0000_1111, 0, 0, "R7 masked irq");
        op(8'h00, 1, 0, 0, 32'h0, 0, 32'h0000_1004, 0, "R8 return from irq");
        op(8'hDA, 0, 0, 0, 32'h0, 32'h0000_3000, 0, 1, "R6 R3 dabt wins hivec");
        op(8'hC8, 0, 0, 0, 32'h0, 32'h0000_3004, 0, 0, "R6 R5 fiq over irq sets F");
        op(8'hC4, 0, 0, 0, 32'h0, 32'h0000_3008, 0, 0, "R7 R6 masked then swi");
        op(8'h00, 0, 1, 1, 32'h2000_0010, 0, 0, 0, "R10 saved write in svc");
        op(8'h00, 1, 0, 0, 32'h0, 0, 32'h0000_4000, 0, "R8 return to user");
        op(8'h0A, 0, 0, 0, 32'h0, 32'h0000_5000, 0, 0, "R6 R4 pabt over undef");
        op(8'h06, 0, 0, 0, 32'h0, 32'h0000_5004, 0, 0, "R6 R4 undef over swi");
        op(8'h04, 1, 1, 0, 32'h0000_001F, 32'h0000_5008, 32'h0000_9999, 0, "R11 swi over return");
        op(8'h01, 0, 0, 0, 32'h0, 32'h0000_6000, 0, 1, "R3 R5 reset request hivec");
        op(8'h00, 0, 1, 0, 32'h0000_001F, 0, 0, 0, "R9 privileged write to system");
        op(8'h00, 0, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, "R10 saved write in system ignored");
        op(8'h00, 1, 0, 0, 32'h0, 0, 32'h0000_7000, 0, "R8 return in system ignored");
        op(8'h80, 0, 0, 0, 32'h0, 32'h0000_7100, 0, 0, "R7 R6 fiq from system");
        idle("R2 strobes drop");
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset after activity");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule